// File: doc/BRIEF.md
# Floating-point status and exception controller

This block holds the status and control word of a floating-point unit. Software reads it on `csr_q` and writes it through a masked write port. The arithmetic unit reports each finished operation with a strobe and five raw exception flags. The block turns that report into three things: a per-operation flag field, an accumulating (sticky) field, and a one-cycle exception request. The request is raised when an accumulated flag meets its enable bit, and it carries a fixed vector code.

The block also decodes two controls from the word. One is the rounding mode, either round-toward-zero or round-to-nearest-even. The other is the flush-to-zero control for denormals. Floating-point compares report here as well. A compare that ends unordered causes a flag update. An ordered result sets or clears the T bit that the pipeline tests.

Register layout (`csr_q`):

| Bits | Field |
|------|-------|
| [1:0] | rounding mode |
| [6:2] | per-operation flags |
| [11:7] | sticky flags |
| [16:12] | enables |
| [17] | flush-to-zero |

All other bits read as zero. The same bit order is used in the per-operation, sticky and enable fields: bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, bit 0 inexact.

Top module: `fpsc_top`

## Requirements
- R1: After reset, `csr_q` is 0, `t_flag` is 0, `exc_req` is 0 and `exc_vector` is 0.
- R2: A write with `wr_en` high makes `csr_q` equal to `wr_data & 32'h0003_FFFF` from the next cycle on. Bits 31:18 always read as 0.
- R3: `round_to_zero` is 1 exactly when `csr_q[1:0]` is 2'b01. Every other value means round-to-nearest-even. `flush_denorm` equals `csr_q[17]`.
- R4: A flag event is either `op_done`, or `cmp_done` with `cmp_rel` equal to 2'b11 (unordered). The cycle after a flag event, `csr_q[6:2]` equals `op_flags` (bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, bit 0 inexact). The field is fully replaced, and zero flags clear it.
- R5: On a flag event, `op_flags` is ORed into `csr_q[11:7]`. Bits 11:7 never clear except through a software write, and the other fields are unchanged.
- R6: `exc_req` is high for one cycle after a flag event exactly when `op_flags` is nonzero and the updated sticky field ANDed with `csr_q[16:12]` is nonzero. While `exc_req` is high, `exc_vector` is 12'h120. Otherwise `exc_vector` is 0.
- R7: When `wr_en` and a flag event occur in the same cycle, the write alone takes effect and no request is raised.
- R8: On `cmp_done`, `cmp_rel` is decoded as 2'b00 less, 2'b01 equal, 2'b10 greater, 2'b11 unordered. On the next cycle `t_flag` is set as follows:
  - `cmp_test_gt` = 0 (equality test): `t_flag` is 1 for equal and 0 for less or greater.
  - `cmp_test_gt` = 1 (greater-than test): `t_flag` is 1 for greater and 0 for less or equal.
  - Ordered results leave the flag fields untouched.
- R9: `t_flag` holds its value when there is no compare, or when the compare is unordered. Writes do not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| op_done | input | 1 | Arithmetic operation finished |
| op_flags | input | 5 | Raw flags of the finished operation or unordered compare |
| cmp_done | input | 1 | Compare finished |
| cmp_test_gt | input | 1 | 1 for a greater-than test, 0 for an equality test |
| cmp_rel | input | 2 | Compare relation |
| csr_q | output | 32 | Status and control word |
| round_to_zero | output | 1 | Round-toward-zero selected |
| flush_denorm | output | 1 | Flush denormals to zero |
| t_flag | output | 1 | Compare result bit |
| exc_req | output | 1 | Exception request pulse |
| exc_vector | output | 12 | Vector code of the request |

## Verification
The assertions check these properties on every cycle:
- the unwritable bits stay zero;
- the sticky field never loses a bit without a write;
- a write lands exactly as masked and suppresses the request;
- every request follows a flag event, has an enabled sticky bit, and carries the right vector;
- `t_flag` holds when no ordered compare occurs.

Other behaviour can only be shown by the bench's reference model under random flag, enable and compare patterns:
- that the per-operation field is replaced rather than merged;
- that a request fires exactly when it should, including the case of zero flags with stale enabled sticky bits;
- that each relation sets `t_flag` correctly.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
    localparam int CSR_W     = 32;
    localparam int FLAG_W    = 5;
    localparam int RM_W      = 2;
    localparam int VEC_W     = 12;
    localparam int RM_LSB    = 0;
    localparam int CUR_LSB   = RM_LSB + RM_W;
    localparam int STK_LSB   = CUR_LSB + FLAG_W;
    localparam int EN_LSB    = STK_LSB + FLAG_W;
    localparam int FTZ_BIT   = EN_LSB + FLAG_W;
    localparam int USED_W    = FTZ_BIT + 1;
    localparam logic [CSR_W-1:0] WR_MASK = {{(CSR_W-USED_W){1'b0}}, {USED_W{1'b1}}};
    localparam logic [RM_W-1:0]  RM_ZERO = 2'b01;
    localparam logic [VEC_W-1:0] EXC_VEC = 12'h120;

    typedef enum logic [1:0] {
        REL_LT    = 2'b00,
        REL_EQ    = 2'b01,
        REL_GT    = 2'b10,
        REL_UNORD = 2'b11
    } cmp_rel_e;

    typedef struct packed {
        logic [CSR_W-1:0] csr;
        logic             tbit;
        logic             req;
    } fpsc_state_t;
endpackage

// File: rtl/fpsc_flag_unit.sv
module fpsc_flag_unit
    import fpsc_pkg::*;
(
    input  logic [CSR_W-1:0]  csr_cur,
    input  logic [FLAG_W-1:0] raw_flags,
    output logic [CSR_W-1:0]  csr_upd,
    output logic              raise
);
    logic [FLAG_W-1:0] sticky_old;
    logic [FLAG_W-1:0] sticky_new;
    logic [FLAG_W-1:0] enables;
    logic [FLAG_W-1:0] hit;

    for (genvar g = 0; g < FLAG_W; g++) begin : g_bit
        assign sticky_old[g] = csr_cur[STK_LSB+g];
        assign enables[g]    = csr_cur[EN_LSB+g];
        assign sticky_new[g] = sticky_old[g] | raw_flags[g];
        assign hit[g]        = sticky_new[g] & enables[g];
    end

    always_comb begin
        csr_upd = csr_cur;
        csr_upd[CUR_LSB +: FLAG_W] = raw_flags;
        csr_upd[STK_LSB +: FLAG_W] = sticky_new;
        raise = (|raw_flags) && (|hit);
    end
endmodule

// File: rtl/fpsc_cmp_unit.sv
module fpsc_cmp_unit
    import fpsc_pkg::*;
(
    input  logic     t_cur,
    input  logic     done,
    input  logic     test_gt,
    input  cmp_rel_e rel,
    output logic     t_next,
    output logic     unord
);
    always_comb begin
        t_next = t_cur;
        unord  = 1'b0;
        if (done) begin
            unique case (rel)
                REL_LT:    t_next = 1'b0;
                REL_EQ:    t_next = ~test_gt;
                REL_GT:    t_next = test_gt;
                REL_UNORD: unord  = 1'b1;
                default:   t_next = t_cur;
            endcase
        end
    end
endmodule

// File: rtl/fpsc_mode_dec.sv
module fpsc_mode_dec
    import fpsc_pkg::*;
(
    input  logic [CSR_W-1:0] csr,
    output logic             rtz,
    output logic             ftz
);
    assign rtz = (csr[RM_LSB +: RM_W] == RM_ZERO);
    assign ftz = csr[FTZ_BIT];
endmodule

// File: rtl/fpsc_top.sv
module fpsc_top
    import fpsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CSR_W-1:0]  wr_data,
    input  logic              op_done,
    input  logic [FLAG_W-1:0] op_flags,
    input  logic              cmp_done,
    input  logic              cmp_test_gt,
    input  logic [1:0]        cmp_rel,
    output logic [CSR_W-1:0]  csr_q,
    output logic              round_to_zero,
    output logic              flush_denorm,
    output logic              t_flag,
    output logic              exc_req,
    output logic [VEC_W-1:0]  exc_vector
);
    fpsc_state_t st_d, st_q;
    logic [CSR_W-1:0] csr_upd;
    logic             raise;
    logic             t_next;
    logic             unord;
    logic             flag_event;

    fpsc_flag_unit u_flag (
        .csr_cur   (st_q.csr),
        .raw_flags (op_flags),
        .csr_upd   (csr_upd),
        .raise     (raise)
    );

    fpsc_cmp_unit u_cmp (
        .t_cur   (st_q.tbit),
        .done    (cmp_done),
        .test_gt (cmp_test_gt),
        .rel     (cmp_rel_e'(cmp_rel)),
        .t_next  (t_next),
        .unord   (unord)
    );

    fpsc_mode_dec u_mode (
        .csr (st_q.csr),
        .rtz (round_to_zero),
        .ftz (flush_denorm)
    );

    assign flag_event = op_done | unord;

    always_comb begin
        st_d      = st_q;
        st_d.req  = 1'b0;
        st_d.tbit = t_next;
        if (wr_en) begin
            st_d.csr = wr_data & WR_MASK;
        end else if (flag_event) begin
            st_d.csr = csr_upd;
            st_d.req = raise;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign csr_q      = st_q.csr;
    assign t_flag     = st_q.tbit;
    assign exc_req    = st_q.req;
    assign exc_vector = st_q.req ? EXC_VEC : '0;
endmodule

// File: rtl/fpsc_checker.sv
module fpsc_checker
    import fpsc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [CSR_W-1:0] wr_data,
    input logic             op_done,
    input logic             cmp_done,
    input logic [1:0]       cmp_rel,
    input logic [CSR_W-1:0] csr_q,
    input logic             t_flag,
    input logic             exc_req,
    input logic [VEC_W-1:0] exc_vector
);
    logic [FLAG_W-1:0] sticky;
    logic [FLAG_W-1:0] enab;
    logic              unord_in;

    assign sticky   = csr_q[STK_LSB +: FLAG_W];
    assign enab     = csr_q[EN_LSB +: FLAG_W];
    assign unord_in = cmp_done && (cmp_rel == REL_UNORD);

    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q & ~WR_MASK) == '0);

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (csr_q == ($past(wr_data) & WR_MASK)));

    a_r7_write_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !exc_req);

    a_r5_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((sticky & $past(sticky)) == $past(sticky)));

    a_r6_req_origin: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> $past(op_done || unord_in));

    a_r6_req_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> ((sticky & enab) != '0));

    a_r6_vector: assert property (@(posedge clk) disable iff (!rst_n)
        exc_vector == (exc_req ? EXC_VEC : '0));

    a_r9_t_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_done || unord_in) |=> $stable(t_flag));
endmodule

bind fpsc_top fpsc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .op_done    (op_done),
    .cmp_done   (cmp_done),
    .cmp_rel    (cmp_rel),
    .csr_q      (csr_q),
    .t_flag     (t_flag),
    .exc_req    (exc_req),
    .exc_vector (exc_vector)
);

// File: tb/fpsc_top_test.sv
`timescale 1ns/1ps
module fpsc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_done = 1'b0;
    logic [4:0]  op_flags = '0;
    logic        cmp_done = 1'b0;
    logic        cmp_test_gt = 1'b0;
    logic [1:0]  cmp_rel = '0;
    logic [31:0] csr_q;
    logic        round_to_zero, flush_denorm, t_flag, exc_req;
    logic [11:0] exc_vector;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [31:0] m_csr = '0;
    logic        m_t = 1'b0;
    logic        m_req = 1'b0;

    always #4 clk = ~clk;

    fpsc_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_done(op_done), .op_flags(op_flags), .cmp_done(cmp_done),
        .cmp_test_gt(cmp_test_gt), .cmp_rel(cmp_rel), .csr_q(csr_q),
        .round_to_zero(round_to_zero), .flush_denorm(flush_denorm),
        .t_flag(t_flag), .exc_req(exc_req), .exc_vector(exc_vector)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic rtz_e;
        rtz_e = (m_csr[1:0] == 2'b01);
        check(csr_q === m_csr, "R2/R4/R5/R7 csr_q", csr_q, m_csr);
        check(round_to_zero === rtz_e, "R3 round_to_zero", {31'd0, round_to_zero}, {31'd0, rtz_e});
        check(flush_denorm === m_csr[17], "R3 flush_denorm", {31'd0, flush_denorm}, {31'd0, m_csr[17]});
        check(t_flag === m_t, "R8/R9 t_flag", {31'd0, t_flag}, {31'd0, m_t});
        check(exc_req === m_req, "R6 exc_req", {31'd0, exc_req}, {31'd0, m_req});
        check(exc_vector === (m_req ? 12'h120 : 12'h000), "R6 exc_vector",
              {20'd0, exc_vector}, m_req ? 32'h120 : 32'h0);
    endtask

    // Drive one cycle of inputs, advance the model at the edge, compare after it.
    task automatic cyc(input bit w, input logic [31:0] wd, input bit od, input logic [4:0] fl,
                       input bit cd, input bit tg, input logic [1:0] rel);
        bit ev;
        logic [4:0] stk;
        wr_en = w; wr_data = wd; op_done = od; op_flags = fl;
        cmp_done = cd; cmp_test_gt = tg; cmp_rel = rel;
        @(posedge clk);
        ev = od || (cd && rel == 2'b11);
        m_req = 1'b0;
        if (w) begin
            m_csr = wd & 32'h0003_FFFF;
        end else if (ev) begin
            stk = m_csr[11:7] | fl;
            m_csr[6:2]  = fl;
            m_csr[11:7] = stk;
            m_req = (fl != 0) && ((stk & m_csr[16:12]) != 0);
        end
        if (cd) begin
            case (rel)
                2'b00: m_t = 1'b0;
                2'b01: m_t = !tg;
                2'b10: m_t = tg;
                default: m_t = m_t;
            endcase
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(csr_q === 32'h0 && t_flag === 1'b0 && exc_req === 1'b0 && exc_vector === 12'h0,
              "R1 reset state", csr_q, 32'h0);

        // R2 masked write, R3 decode
        cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        cyc(1, 32'h0000_0001, 0, 0, 0, 0, 0);
        cyc(1, 32'h0002_0002, 0, 0, 0, 0, 0);
        // R4/R5/R6: enable invalid only, then raise various flags
        cyc(1, 32'h0001_0000, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 5'b00001, 0, 0, 0);
        cyc(0, 0, 1, 5'b10000, 0, 0, 0);
        cyc(0, 0, 1, 5'b00000, 0, 0, 0);   // R6 zero flags, stale enabled sticky: no request
        cyc(0, 0, 1, 5'b00010, 0, 0, 0);   // R6 nonzero flags with stale enabled sticky
        // R7 write and op together
        cyc(1, 32'h0001_F000, 1, 5'b11111, 0, 0, 0);
        // R8 compares
        cyc(0, 0, 0, 0, 1, 0, 2'b01);
        cyc(0, 0, 0, 0, 1, 1, 2'b01);
        cyc(0, 0, 0, 0, 1, 1, 2'b10);
        cyc(0, 0, 0, 0, 1, 0, 2'b00);
        cyc(0, 0, 0, 0, 1, 0, 2'b10);
        cyc(0, 0, 0, 0, 1, 1, 2'b10);
        cyc(0, 0, 0, 0, 1, 0, 2'b11);      // R9 unordered holds T, R4 flag update
        cyc(0, 0, 0, 0, 0, 0, 2'b01);      // R9 no compare holds T

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[3:0] == 0, $urandom, r[6:4] < 3, r[11:7],
                r[14:12] < 3, r[15], r[17:16]);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule